// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block translates a 32-bit processor address into a routing decision using eight independently programmable windows. Each window holds four 32-bit registers: a control word (enable, target tag, attribute tag and a size mask), a base address, a low remap address and a high remap word. A lookup compares the address against every enabled window at once. The result reports whether a window matched, which window won, its target and attribute tags, the translated address and the high remap word to be used as an upper address extension.

Window size is given in 64 KB units as a mask that fills from the least significant bit: a mask with N ones covers 2^N blocks of 64 KB. Address bits that the mask covers form the offset inside the window. The other upper bits must match the base, and in the translated address they come from the low remap register. If a window should not translate, software loads its low remap register with the base value. Software programs the windows through a flat register port, and each lookup returns its result one clock after it is presented.

Top module: `addrwin_decoder`

## Requirements
- R1: The register index `reg_addr` selects window `reg_addr[4:2]` and register `reg_addr[1:0]`, where 0 is control, 1 is base, 2 is low remap and 3 is high remap. A write with `reg_wr` high stores all 32 bits on the clock edge, and `reg_rdata` returns the addressed register combinationally.
- R2: After reset, every register of every window reads zero and every lookup misses.
- R3: The control word holds the enable in bit 0, the target tag in bits [7:4], the attribute in bits [15:8] and the size mask in bits [31:16]. An enabled window matches when the address bits [31:16], with the mask bits cleared, equal the base bits [31:16] with the same bits cleared.
- R4: A size mask of zero gives a 64 KB window, so only addresses with the same bits [31:16] as the base match.
- R5: A size mask of 0x00FF gives a 16 MB window, so any address that agrees with the base in bits [31:24] matches.
- R6: A window with its enable bit clear never matches, whatever its other fields hold, and each window is enabled or disabled on its own.
- R7: When several windows match, the result reports the lowest-numbered one.
- R8: On a hit, translated address bits [15:0] and the bits under the mask come from the lookup address, and the other bits of [31:16] come from the winner's low remap register. If low remap equals base, the translated address equals the lookup address.
- R9: On a hit, `res_addr_hi` carries the winner's high remap register and `res_target`/`res_attr` carry its tags.
- R10: On a miss, `res_miss` is high, `res_hit` is low, and `res_win`, `res_target`, `res_attr` and `res_addr_hi` are zero. `res_addr` equals the lookup address.
- R11: A lookup presented with `lk_valid` high yields `res_valid` and exactly one of `res_hit`/`res_miss` on the next clock. In a cycle after one without a lookup, `res_valid`, `res_hit` and `res_miss` are all low.
- R12: A lookup made in the same cycle as a register write sees the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Window index and register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed register contents |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | A window matched |
| res_miss | output | 1 | No window matched |
| res_win | output | 3 | Winning window index |
| res_target | output | 4 | Winner's target tag |
| res_attr | output | 8 | Winner's attribute tag |
| res_addr | output | 32 | Translated address |
| res_addr_hi | output | 32 | Winner's high remap word |

## Verification
The assertions check the lookup handshake on every cycle: one result per request, silence after idle cycles, hit and miss never both high, zeroed tags on a miss, the lookup address passed through on a miss, and the offset bits carried through on every lookup. Which window wins, the mask arithmetic for the 64 KB and 16 MB cases, the effect of disabling a window, remapping, and the old-versus-new ordering of a write beside a lookup all depend on programmed contents. The bench's reference model shows those through its scenarios.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
  localparam int AW_ADDR_W    = 32;
  localparam int AW_GRAN_BITS = 16;
  localparam int AW_NUM_WIN   = 8;
  localparam int AW_TGT_W     = 4;
  localparam int AW_ATTR_W    = 8;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_TGT_LSB  = 4;
  localparam int CTL_ATTR_LSB = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } win_sel_e;
endpackage

// File: rtl/addrwin_regfile.sv
module addrwin_regfile
  import addrwin_pkg::*;
#(
  parameter int NUM_WIN   = AW_NUM_WIN,
  parameter int ADDR_W    = AW_ADDR_W,
  parameter int GRAN_BITS = AW_GRAN_BITS,
  parameter int TGT_W     = AW_TGT_W,
  parameter int ATTR_W    = AW_ATTR_W,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int RA_W     = IDX_W + 2,
  localparam int HI_W     = ADDR_W - GRAN_BITS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [RA_W-1:0]                 reg_idx,
  input  logic [ADDR_W-1:0]               wr_data,
  output logic [ADDR_W-1:0]               rd_data,
  output logic [NUM_WIN-1:0]              win_en,
  output logic [NUM_WIN-1:0][TGT_W-1:0]   win_tgt,
  output logic [NUM_WIN-1:0][ATTR_W-1:0]  win_attr,
  output logic [NUM_WIN-1:0][HI_W-1:0]    win_size,
  output logic [NUM_WIN-1:0][HI_W-1:0]    win_base,
  output logic [NUM_WIN-1:0][HI_W-1:0]    win_rlo,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_rhi
);
  logic [ADDR_W-1:0] ctrl_a [NUM_WIN];
  logic [ADDR_W-1:0] base_a [NUM_WIN];
  logic [ADDR_W-1:0] rlo_a  [NUM_WIN];
  logic [ADDR_W-1:0] rhi_a  [NUM_WIN];

  win_sel_e        sel;
  logic [IDX_W-1:0] win_idx;

  assign sel     = win_sel_e'(reg_idx[1:0]);
  assign win_idx = reg_idx[RA_W-1:2];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              hit_w;
    logic              we_ctrl, we_base, we_rlo, we_rhi;
    logic [ADDR_W-1:0] ctrl_q, base_q, rlo_q, rhi_q;
    logic [ADDR_W-1:0] ctrl_d, base_d, rlo_d, rhi_d;

    assign hit_w   = wr_en && (win_idx == IDX_W'(w));
    assign we_ctrl = hit_w && (sel == SEL_CTRL);
    assign we_base = hit_w && (sel == SEL_BASE);
    assign we_rlo  = hit_w && (sel == SEL_RLO);
    assign we_rhi  = hit_w && (sel == SEL_RHI);

    always_comb begin
      ctrl_d = we_ctrl ? wr_data : ctrl_q;
      base_d = we_base ? wr_data : base_q;
      rlo_d  = we_rlo  ? wr_data : rlo_q;
      rhi_d  = we_rhi  ? wr_data : rhi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        base_q <= '0;
        rlo_q  <= '0;
        rhi_q  <= '0;
      end else begin
        ctrl_q <= ctrl_d;
        base_q <= base_d;
        rlo_q  <= rlo_d;
        rhi_q  <= rhi_d;
      end
    end

    assign ctrl_a[w]   = ctrl_q;
    assign base_a[w]   = base_q;
    assign rlo_a[w]    = rlo_q;
    assign rhi_a[w]    = rhi_q;

    assign win_en[w]   = ctrl_q[CTL_EN_BIT];
    assign win_tgt[w]  = ctrl_q[CTL_TGT_LSB +: TGT_W];
    assign win_attr[w] = ctrl_q[CTL_ATTR_LSB +: ATTR_W];
    assign win_size[w] = ctrl_q[ADDR_W-1 -: HI_W];
    assign win_base[w] = base_q[ADDR_W-1 -: HI_W];
    assign win_rlo[w]  = rlo_q[ADDR_W-1 -: HI_W];
    assign win_rhi[w]  = rhi_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_data = ctrl_a[win_idx];
      SEL_BASE: rd_data = base_a[win_idx];
      SEL_RLO:  rd_data = rlo_a[win_idx];
      default:  rd_data = rhi_a[win_idx];
    endcase
  end
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match #(
  parameter int NUM_WIN = 8,
  parameter int HI_W    = 16
) (
  input  logic [HI_W-1:0]              addr_hi,
  input  logic [NUM_WIN-1:0]           win_en,
  input  logic [NUM_WIN-1:0][HI_W-1:0] win_size,
  input  logic [NUM_WIN-1:0][HI_W-1:0] win_base,
  output logic [NUM_WIN-1:0]           hit_vec
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [HI_W-1:0] keep;
    assign keep       = ~win_size[w];
    assign hit_vec[w] = win_en[w] && ((addr_hi & keep) == (win_base[w] & keep));
  end
endmodule

// File: rtl/addrwin_select.sv
module addrwin_select #(
  parameter int NUM_WIN  = 8,
  parameter int ADDR_W   = 32,
  parameter int HI_W     = 16,
  parameter int TGT_W    = 4,
  parameter int ATTR_W   = 8,
  localparam int IDX_W   = $clog2(NUM_WIN),
  localparam int LO_W    = ADDR_W - HI_W
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_WIN-1:0]             hit_vec,
  input  logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt,
  input  logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr,
  input  logic [NUM_WIN-1:0][HI_W-1:0]   win_size,
  input  logic [NUM_WIN-1:0][HI_W-1:0]   win_rlo,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_rhi,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               sel_idx,
  output logic [TGT_W-1:0]               sel_tgt,
  output logic [ATTR_W-1:0]              sel_attr,
  output logic [ADDR_W-1:0]              sel_addr,
  output logic [ADDR_W-1:0]              sel_rhi
);
  logic [HI_W-1:0] mask;
  logic [HI_W-1:0] new_hi;

  always_comb begin
    any_hit = 1'b0;
    sel_idx = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit_vec[w] && !any_hit) begin
        any_hit = 1'b1;
        sel_idx = IDX_W'(w);
      end
    end
  end

  assign mask   = win_size[sel_idx];
  assign new_hi = (win_rlo[sel_idx] & ~mask) | (addr[ADDR_W-1 -: HI_W] & mask);

  always_comb begin
    if (any_hit) begin
      sel_tgt  = win_tgt[sel_idx];
      sel_attr = win_attr[sel_idx];
      sel_addr = {new_hi, addr[LO_W-1:0]};
      sel_rhi  = win_rhi[sel_idx];
    end else begin
      sel_tgt  = '0;
      sel_attr = '0;
      sel_addr = addr;
      sel_rhi  = '0;
    end
  end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
  import addrwin_pkg::*;
#(
  parameter int NUM_WIN   = AW_NUM_WIN,
  parameter int ADDR_W    = AW_ADDR_W,
  parameter int GRAN_BITS = AW_GRAN_BITS,
  parameter int TGT_W     = AW_TGT_W,
  parameter int ATTR_W    = AW_ATTR_W,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int RA_W     = IDX_W + 2,
  localparam int HI_W     = ADDR_W - GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_win,
  output logic [TGT_W-1:0]  res_target,
  output logic [ATTR_W-1:0] res_attr,
  output logic [ADDR_W-1:0] res_addr,
  output logic [ADDR_W-1:0] res_addr_hi
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt;
  logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr;
  logic [NUM_WIN-1:0][HI_W-1:0]   win_size;
  logic [NUM_WIN-1:0][HI_W-1:0]   win_base;
  logic [NUM_WIN-1:0][HI_W-1:0]   win_rlo;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_rhi;
  logic [NUM_WIN-1:0]             hit_vec;

  logic              any_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [TGT_W-1:0]  sel_tgt;
  logic [ATTR_W-1:0] sel_attr;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] sel_rhi;

  addrwin_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS),
    .TGT_W(TGT_W), .ATTR_W(ATTR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(reg_wr), .reg_idx(reg_addr), .wr_data(reg_wdata), .rd_data(reg_rdata),
    .win_en(win_en), .win_tgt(win_tgt), .win_attr(win_attr),
    .win_size(win_size), .win_base(win_base), .win_rlo(win_rlo), .win_rhi(win_rhi)
  );

  addrwin_match #(.NUM_WIN(NUM_WIN), .HI_W(HI_W)) u_match (
    .addr_hi(lk_addr[ADDR_W-1 -: HI_W]),
    .win_en(win_en), .win_size(win_size), .win_base(win_base),
    .hit_vec(hit_vec)
  );

  addrwin_select #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .HI_W(HI_W), .TGT_W(TGT_W), .ATTR_W(ATTR_W)
  ) u_sel (
    .addr(lk_addr), .hit_vec(hit_vec),
    .win_tgt(win_tgt), .win_attr(win_attr), .win_size(win_size),
    .win_rlo(win_rlo), .win_rhi(win_rhi),
    .any_hit(any_hit), .sel_idx(sel_idx), .sel_tgt(sel_tgt), .sel_attr(sel_attr),
    .sel_addr(sel_addr), .sel_rhi(sel_rhi)
  );

  logic              valid_d, hit_d, miss_d;
  logic [IDX_W-1:0]  win_d;
  logic [TGT_W-1:0]  tgt_d;
  logic [ATTR_W-1:0] attr_d;
  logic [ADDR_W-1:0] addr_d, addr_hi_d;

  always_comb begin
    valid_d   = lk_valid;
    hit_d     = lk_valid && any_hit;
    miss_d    = lk_valid && !any_hit;
    win_d     = any_hit ? sel_idx : '0;
    tgt_d     = sel_tgt;
    attr_d    = sel_attr;
    addr_d    = sel_addr;
    addr_hi_d = sel_rhi;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_hit   <= hit_d;
      res_miss  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_win     <= '0;
      res_target  <= '0;
      res_attr    <= '0;
      res_addr    <= '0;
      res_addr_hi <= '0;
    end else if (lk_valid) begin
      res_win     <= win_d;
      res_target  <= tgt_d;
      res_attr    <= attr_d;
      res_addr    <= addr_d;
      res_addr_hi <= addr_hi_d;
    end
  end
endmodule

// File: rtl/addrwin_checker.sv
module addrwin_checker #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 16,
  parameter int IDX_W     = 3,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_miss,
  input logic [IDX_W-1:0]  res_win,
  input logic [TGT_W-1:0]  res_target,
  input logic [ATTR_W-1:0] res_attr,
  input logic [ADDR_W-1:0] res_addr,
  input logic [ADDR_W-1:0] res_addr_hi
);
  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid && (res_hit ^ res_miss));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid && !res_hit && !res_miss);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_target == '0) && (res_attr == '0) && (res_win == '0) && (res_addr_hi == '0));

  assert_miss_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!res_miss || (res_addr == $past(lk_addr))));

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (res_addr[GRAN_BITS-1:0] == $past(lk_addr[GRAN_BITS-1:0])));
endmodule

bind addrwin_decoder addrwin_checker #(
  .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .IDX_W(IDX_W), .TGT_W(TGT_W), .ATTR_W(ATTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .lk_valid(lk_valid), .lk_addr(lk_addr),
  .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
  .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
  .res_addr(res_addr), .res_addr_hi(res_addr_hi)
);

// File: tb/sim_addrwin_decoder.sv
`timescale 1ns/1ps
module sim_addrwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr, res_addr_hi;

  always #5 clk = ~clk;

  addrwin_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr), .res_addr_hi(res_addr_hi)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] m_reg [32];

  logic        e_valid, e_hit, e_miss;
  logic [2:0]  e_win;
  logic [3:0]  e_tgt;
  logic [7:0]  e_attr;
  logic [31:0] e_addr, e_hi;

  function automatic logic [31:0] mk_ctrl(input bit en, input int tgt, input int attr, input int size);
    return {size[15:0], attr[7:0], tgt[3:0], 3'b000, en};
  endfunction

  task automatic predict(input bit v, input logic [31:0] a);
    bit found = 0;
    e_valid = v;
    e_hit   = 0;
    e_miss  = 0;
    if (!v) return;
    for (int w = 0; w < 8; w++) begin
      logic [31:0] c  = m_reg[w*4+0];
      logic [15:0] sz = c[31:16];
      if (!found && c[0] && ((a[31:16] & ~sz) == (m_reg[w*4+1][31:16] & ~sz))) begin
        found  = 1;
        e_win  = w[2:0];
        e_tgt  = c[7:4];
        e_attr = c[15:8];
        e_addr = {(m_reg[w*4+2][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
        e_hi   = m_reg[w*4+3];
      end
    end
    e_hit = found;
    e_miss = !found;
    if (!found) begin
      e_win = 0; e_tgt = 0; e_attr = 0; e_addr = a; e_hi = 0;
    end
  endtask

  task automatic cycle(input string tag, input bit wr, input int ridx, input logic [31:0] wd,
                       input bit lv, input logic [31:0] la);
    reg_wr    = wr;
    reg_addr  = ridx[4:0];
    reg_wdata = wd;
    lk_valid  = lv;
    lk_addr   = la;
    predict(lv, la);
    if (wr) m_reg[ridx] = wd;
    @(negedge clk);
    reg_wr   = 0;
    lk_valid = 0;
    tests++;
    if (res_valid !== e_valid || res_hit !== e_hit || res_miss !== e_miss ||
        res_win !== e_win || res_target !== e_tgt || res_attr !== e_attr ||
        res_addr !== e_addr || res_addr_hi !== e_hi) begin
      fails++;
      $display("FAIL %s: got v%0b h%0b m%0b w%0d t%h a%h ad%h hi%h exp v%0b h%0b m%0b w%0d t%h a%h ad%h hi%h",
               tag, res_valid, res_hit, res_miss, res_win, res_target, res_attr, res_addr, res_addr_hi,
               e_valid, e_hit, e_miss, e_win, e_tgt, e_attr, e_addr, e_hi);
    end
  endtask

  task automatic check_read(input string tag, input int ridx);
    reg_addr = ridx[4:0];
    #1;
    tests++;
    if (reg_rdata !== m_reg[ridx]) begin
      fails++;
      $display("FAIL %s: reg %0d got %h exp %h", tag, ridx, reg_rdata, m_reg[ridx]);
    end
  endtask

  task automatic wr(input string tag, input int w, input int sel, input logic [31:0] d);
    cycle(tag, 1, w*4+sel, d, 0, 32'h0);
  endtask

  task automatic lk(input string tag, input logic [31:0] a);
    cycle(tag, 0, 0, 32'h0, 1, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
    e_win = 0; e_tgt = 0; e_attr = 0; e_addr = 0; e_hi = 0;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; lk_valid = 0; lk_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: reset state
    cycle("R2 idle after reset", 0, 0, 0, 0, 0);
    for (int i = 0; i < 32; i++) check_read("R2 reset read", i);
    lk("R2 lookup after reset", 32'h9000_1234);

    // R1: write and read back every register, enable kept clear
    for (int i = 0; i < 32; i++)
      wr("R1 write", i / 4, i % 4, {i[7:0], 8'h5A, ~i[7:0], 8'hC2});
    for (int i = 0; i < 32; i++) check_read("R1 readback", i);
    lk("R6 all disabled", 32'h5AC2_0000);

    // window 0: 256 MB, identity remap
    wr("R3 cfg", 0, 1, 32'h9000_0000);
    wr("R3 cfg", 0, 2, 32'h9000_0000);
    wr("R3 cfg", 0, 3, 32'h0);
    wr("R3 cfg", 0, 0, mk_ctrl(1, 4, 8'hE8, 16'h0FFF));
    lk("R3 hit", 32'h9123_4567);
    lk("R8 identity", 32'h9FFF_FFFF);
    lk("R3 miss", 32'hA000_0000);

    // window 1: 64 KB
    wr("R4 cfg", 1, 1, 32'hF100_0000);
    wr("R4 cfg", 1, 2, 32'hC000_0000);
    wr("R4 cfg", 1, 3, 32'h0000_0012);
    wr("R4 cfg", 1, 0, mk_ctrl(1, 2, 8'h1D, 0));
    lk("R4 inside", 32'hF100_ABCD);
    lk("R4 next block", 32'hF101_0000);
    lk("R4 prev block", 32'hF0FF_FFFF);

    // window 2: 16 MB with remap
    wr("R5 cfg", 2, 1, 32'hD800_0000);
    wr("R5 cfg", 2, 2, 32'h2000_0000);
    wr("R5 cfg", 2, 3, 32'hABCD_0001);
    wr("R5 cfg", 2, 0, mk_ctrl(1, 9, 8'h33, 16'h00FF));
    lk("R5 low edge", 32'hD800_0000);
    lk("R8 R9 remap", 32'hD8AB_CDEF);
    lk("R5 high edge", 32'hD8FF_FFFF);
    lk("R5 outside", 32'hD900_0000);

    // window 5 overlaps window 0
    wr("R7 cfg", 5, 1, 32'h9000_0000);
    wr("R7 cfg", 5, 2, 32'h4000_0000);
    wr("R7 cfg", 5, 3, 32'h0000_0055);
    wr("R7 cfg", 5, 0, mk_ctrl(1, 7, 8'h77, 16'h7FFF));
    lk("R7 lowest wins", 32'h9800_0010);
    lk("R7 only upper", 32'hB000_0020);
    wr("R6 disable w0", 0, 0, mk_ctrl(0, 4, 8'hE8, 16'h0FFF));
    lk("R6 w0 off", 32'h9800_0010);
    wr("R6 enable w0", 0, 0, mk_ctrl(1, 4, 8'hE8, 16'h0FFF));
    lk("R7 w0 back", 32'h9800_0010);

    // R12: write and lookup in the same cycle
    cycle("R12 old contents", 1, 2*4+0, mk_ctrl(0, 9, 8'h33, 16'h00FF), 1, 32'hD812_3456);
    lk("R12 new contents", 32'hD812_3456);
    cycle("R12 base move", 1, 1*4+1, 32'hF200_0000, 1, 32'hF200_0001);
    lk("R12 base moved", 32'hF200_0001);

    // R11: idle gaps and back-to-back
    cycle("R11 idle", 0, 0, 0, 0, 32'hFFFF_FFFF);
    cycle("R11 idle", 0, 0, 0, 0, 32'h0);
    lk("R11 b2b", 32'h9000_0000);
    lk("R11 b2b", 32'h1234_5678);

    // sweep across the whole space
    for (int i = 0; i < 512; i++)
      cycle("R10 sweep", 0, 0, 0, (i % 3) != 2, {i[8:0], 7'h00, 16'h0} ^ 32'h0000_A5A5 ^ (i * 32'h0001_0011));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule